// File: doc/BRIEF.md
# Selectable Pin Interrupt Channels

This block turns a bank of general-purpose pin inputs into 32 interrupt channels. Each channel chooses any one of up to 86 pins through its own source field, carries its own enable, and applies one of four sense modes: rising edge, falling edge, high level or low level. A detected event latches a per-channel flag. The flag, gated by the channel's enable, drives a level request toward the parent interrupt controller.

Software programs the block through a simple 32-bit register bus with a write strobe and a combinational read path. Edge-mode flags are sticky until software writes a one to the channel's bit in the clear register. Level-mode flags follow the selected pin and ignore clear writes. Pins pass through a two-stage synchronizer before detection. Moving a channel to a different pin reloads its edge history, so the reselect does not raise a false edge.

Top module: `pinirq_top`

## Requirements
- R1: After reset every flag, every request output and every configuration register read as zero.
- R2: Channel c's 8-bit configuration field sits in the word at offset 0x30 + 4*(c/4), bits 8*(c%4) up. The low 7 bits select the pin and bit 7 is the enable. Its 2-bit sense field sits in the word at 0x28 + 4*(c/16), bits 2*(c%16) up. All of these read back as written. A write to the clear register at 0x24 leaves every configuration field unchanged.
- R3: A select value above 85 routes no pin, so the channel never sets its flag or raises its request, in any sense mode.
- R4: Sense code 0 sets the flag on a rising pin and code 1 on a falling pin. The other edge does nothing. The flag is visible in status bit c at 0x20, and on `irqOut[c]`, at the third rising clock edge after the pin changes.
- R5: An edge-mode flag stays set until a write to 0x24 carries a one in bit c. Zero bits in that write have no effect.
- R6: Sense code 2 (high level) and code 3 (low level) make the flag follow the selected pin. A clear write does not change it.
- R7: A disabled channel never sets its flag and keeps `irqOut[c]` low. A flag that is already latched stays set and can still be cleared. Enabling a channel does not by itself produce an edge.
- R8: Changing a channel's select field to a pin at a different level does not set the flag. A clear written after the update leaves no pending flag.
- R9: When an edge is detected in the same cycle that a clear write hits the channel, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 86 | Asynchronous pin inputs |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 12 | Register byte address |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| irqOut | output | 32 | Per-channel level interrupt request |

## Verification
The hardest case to reach is an edge that is detected in exactly the cycle a clear write lands. The bench reaches it by counting the synchronizer stages: it toggles the pin, then starts the clear write two falling clock edges later, so that the write commits on the same rising edge as the detection. Two other cases also need planned stimulus. For the reselect case, neighbouring pins are parked at opposite levels before the channel is moved between them. For the disabled case, a flag is latched first and the channel is disabled afterwards.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int CH_NUM            = 32;
  localparam int FIELD_W           = 8;
  localparam int SEL_W             = FIELD_W - 1;
  localparam int SENSE_W           = 2;
  localparam int CH_PER_SEL_WORD   = 32 / FIELD_W;
  localparam int CH_PER_SENSE_WORD = 32 / SENSE_W;
  localparam int SEL_WORDS         = CH_NUM / CH_PER_SEL_WORD;
  localparam int SENSE_WORDS       = CH_NUM / CH_PER_SENSE_WORD;

  localparam int OFF_STATUS = 'h020;
  localparam int OFF_CLEAR  = 'h024;
  localparam int OFF_SENSE  = 'h028;
  localparam int OFF_SELECT = 'h030;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  typedef struct packed {
    logic [CH_NUM-1:0] clrHit;
    logic [CH_NUM-1:0] reselect;
  } strobe_t;
endpackage

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
  import pinirq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busWrEn,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [31:0]                     busWrData,
  output logic [31:0]                     busRdData,
  input  logic [CH_NUM-1:0]               statusIn,
  output logic [CH_NUM-1:0][SEL_W-1:0]    selQ,
  output logic [CH_NUM-1:0][SEL_W-1:0]    selNext,
  output logic [CH_NUM-1:0]               enQ,
  output logic [CH_NUM-1:0][SENSE_W-1:0]  senseQ,
  output strobe_t                         strobe
);

  logic clrWr;
  assign clrWr = busWrEn && (busAddr == ADDR_W'(OFF_CLEAR));
  assign strobe.clrHit = clrWr ? busWrData[CH_NUM-1:0] : '0;

  for (genvar c = 0; c < CH_NUM; c++) begin : gChan
    localparam int SW = c / CH_PER_SEL_WORD;
    localparam int SL = (c % CH_PER_SEL_WORD) * FIELD_W;
    localparam int NW = c / CH_PER_SENSE_WORD;
    localparam int NL = (c % CH_PER_SENSE_WORD) * SENSE_W;

    logic               selWr;
    logic               senseWr;
    logic [FIELD_W-1:0] fieldIn;
    logic [SEL_W-1:0]   selR;
    logic               enR;
    logic [SENSE_W-1:0] senseR;

    assign selWr   = busWrEn && (busAddr == ADDR_W'(OFF_SELECT + 4 * SW));
    assign senseWr = busWrEn && (busAddr == ADDR_W'(OFF_SENSE + 4 * NW));
    assign fieldIn = busWrData[SL +: FIELD_W];

    assign selNext[c]         = selWr ? fieldIn[SEL_W-1:0] : selR;
    assign strobe.reselect[c] = selWr && (fieldIn[SEL_W-1:0] != selR);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selR   <= '0;
        enR    <= 1'b0;
        senseR <= '0;
      end else begin
        if (selWr) begin
          selR <= fieldIn[SEL_W-1:0];
          enR  <= fieldIn[FIELD_W-1];
        end
        if (senseWr) senseR <= busWrData[NL +: SENSE_W];
      end
    end

    assign selQ[c]   = selR;
    assign enQ[c]    = enR;
    assign senseQ[c] = senseR;
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(OFF_STATUS)) busRdData[CH_NUM-1:0] = statusIn;
    for (int w = 0; w < SENSE_WORDS; w++) begin
      if (busAddr == ADDR_W'(OFF_SENSE + 4 * w)) begin
        for (int i = 0; i < CH_PER_SENSE_WORD; i++)
          busRdData[SENSE_W*i +: SENSE_W] = senseQ[w*CH_PER_SENSE_WORD + i];
      end
    end
    for (int w = 0; w < SEL_WORDS; w++) begin
      if (busAddr == ADDR_W'(OFF_SELECT + 4 * w)) begin
        for (int i = 0; i < CH_PER_SEL_WORD; i++)
          busRdData[FIELD_W*i +: FIELD_W] =
            {enQ[w*CH_PER_SEL_WORD + i], selQ[w*CH_PER_SEL_WORD + i]};
      end
    end
  end

  AST_CLEAR_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> ($stable(senseQ) && $stable(selQ) && $stable(enQ))); // R2

endmodule

// File: rtl/pinirq_datapath.sv
module pinirq_datapath
  import pinirq_pkg::*;
#(
  parameter int PIN_NUM = 86
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [PIN_NUM-1:0]              pinIn,
  input  logic [CH_NUM-1:0][SEL_W-1:0]    selQ,
  input  logic [CH_NUM-1:0][SEL_W-1:0]    selNext,
  input  logic [CH_NUM-1:0]               enQ,
  input  logic [CH_NUM-1:0][SENSE_W-1:0]  senseQ,
  input  strobe_t                         strobe,
  output logic [CH_NUM-1:0]               flagQ,
  output logic [CH_NUM-1:0]               irqOut
);

  logic [PIN_NUM-1:0] pinMeta;
  logic [PIN_NUM-1:0] pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinMeta <= '0;
      pinSync <= '0;
    end else begin
      pinMeta <= pinIn;
      pinSync <= pinMeta;
    end
  end

  function automatic logic routeOf(input logic [PIN_NUM-1:0] pins,
                                   input logic [SEL_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int p = 0; p < PIN_NUM; p++)
      if (int'(s) == p) r = pins[p];
    return r;
  endfunction

  logic [CH_NUM-1:0] validSel;
  logic [CH_NUM-1:0] active;
  logic [CH_NUM-1:0] levelV;
  logic [CH_NUM-1:0] matchV;
  logic [CH_NUM-1:0] setEv;

  for (genvar c = 0; c < CH_NUM; c++) begin : gChan
    logic routed;
    logic prevR;
    logic flagR;
    logic edgeHit;

    assign validSel[c] = int'(selQ[c]) < PIN_NUM;
    assign routed      = routeOf(pinSync, selQ[c]);
    assign active[c]   = enQ[c] & validSel[c];
    assign levelV[c]   = senseQ[c][1];
    assign matchV[c]   = (senseQ[c] == SENSE_HIGH) ? routed : ~routed;

    always_comb begin
      case (sense_e'(senseQ[c]))
        SENSE_RISE: edgeHit = routed & ~prevR;
        SENSE_FALL: edgeHit = ~routed & prevR;
        default:    edgeHit = 1'b0;
      endcase
    end
    assign setEv[c] = active[c] & edgeHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevR <= 1'b0;
        flagR <= 1'b0;
      end else begin
        prevR <= strobe.reselect[c] ? routeOf(pinSync, selNext[c]) : routed;
        if (levelV[c]) begin
          if (active[c]) flagR <= matchV[c];
        end else if (setEv[c]) begin
          flagR <= 1'b1;
        end else if (strobe.clrHit[c]) begin
          flagR <= 1'b0;
        end
      end
    end

    assign flagQ[c]  = flagR;
    assign irqOut[c] = flagR & active[c];
  end

  AST_NO_SET_WHILE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagQ & ~$past(flagQ) & ~$past(active)) == '0)); // R7
  AST_BAD_SEL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagQ & ~$past(flagQ) & ~$past(validSel)) == '0)); // R3
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(flagQ & ~levelV & ~strobe.clrHit) & ~flagQ) == '0)); // R5
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(setEv) & ~flagQ) == '0)); // R9
  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(active & levelV) & (flagQ ^ $past(matchV))) == '0)); // R6

endmodule

// File: rtl/pinirq_top.sv
module pinirq_top
  import pinirq_pkg::*;
#(
  parameter int PIN_NUM = 86,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_NUM-1:0] pinIn,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic [CH_NUM-1:0]  irqOut
);

  logic [CH_NUM-1:0][SEL_W-1:0]   selQ;
  logic [CH_NUM-1:0][SEL_W-1:0]   selNext;
  logic [CH_NUM-1:0]              enQ;
  logic [CH_NUM-1:0][SENSE_W-1:0] senseQ;
  logic [CH_NUM-1:0]              flagQ;
  strobe_t                        strobe;

  pinirq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .statusIn(flagQ),
    .selQ(selQ), .selNext(selNext), .enQ(enQ), .senseQ(senseQ),
    .strobe(strobe)
  );

  pinirq_datapath #(.PIN_NUM(PIN_NUM)) uData (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .selQ(selQ), .selNext(selNext), .enQ(enQ), .senseQ(senseQ),
    .strobe(strobe), .flagQ(flagQ), .irqOut(irqOut)
  );

endmodule

// File: tb/pinirq_top_test.sv
module pinirq_top_test;
  localparam int PINS = 86;
  localparam int CHS  = 32;
  localparam logic [11:0] A_STAT  = 12'h020;
  localparam logic [11:0] A_CLR   = 12'h024;
  localparam logic [11:0] A_SENSE = 12'h028;
  localparam logic [11:0] A_SEL   = 12'h030;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PINS-1:0] pins = '0;
  logic            busWrEn = 1'b0;
  logic [11:0]     busAddr = A_STAT;
  logic [31:0]     busWrData = '0;
  logic [31:0]     busRdData;
  logic [CHS-1:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] shSel [CHS];
  logic [1:0] shSense [CHS];

  always #2 clk = ~clk;

  pinirq_top uut (
    .clk(clk), .rstN(rstN), .pinIn(pins), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = A_STAT; busWrData = '0;
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
    busAddr = A_STAT;
  endtask

  function automatic logic [31:0] selWord(input int w);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) v[8*i +: 8] = shSel[4*w + i];
    return v;
  endfunction

  function automatic logic [31:0] senseWord(input int w);
    logic [31:0] v;
    for (int i = 0; i < 16; i++) v[2*i +: 2] = shSense[16*w + i];
    return v;
  endfunction

  task automatic setChan(input int c, input int sel, input logic en);
    shSel[c] = {en, 7'(sel)};
    wrReg(A_SEL + 12'(4 * (c / 4)), selWord(c / 4));
  endtask

  task automatic setSense(input int c, input logic [1:0] m);
    shSense[c] = m;
    wrReg(A_SENSE + 12'(4 * (c / 16)), senseWord(c / 16));
  endtask

  task automatic expectChan(input string req, input int c, input logic st, input logic irq);
    logic [31:0] v;
    rdReg(A_STAT, v);
    chk(req, 32'(v[c]), 32'(st));
    chk(req, 32'(irqOut[c]), 32'(irq));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < CHS; c++) begin shSel[c] = '0; shSense[c] = '0; end
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    rdReg(A_STAT, v); chk("R1 status", v, 32'h0);
    chk("R1 irqOut", irqOut, 32'h0);
    for (int w = 0; w < 8; w++) begin rdReg(A_SEL + 12'(4*w), v); chk("R1 select", v, 32'h0); end
    for (int w = 0; w < 2; w++) begin rdReg(A_SENSE + 12'(4*w), v); chk("R1 sense", v, 32'h0); end

    // R2: sense words read back, then restore
    for (int w = 0; w < 2; w++) begin
      wrReg(A_SENSE + 12'(4*w), 32'hE41B_C936 ^ 32'(w * 32'h0101_0101));
      rdReg(A_SENSE + 12'(4*w), v);
      chk("R2 sense readback", v, 32'hE41B_C936 ^ 32'(w * 32'h0101_0101));
    end
    for (int w = 0; w < 2; w++) wrReg(A_SENSE + 12'(4*w), 32'h0);
    // R2: select words read back, clear write keeps them
    for (int w = 0; w < 8; w++) wrReg(A_SEL + 12'(4*w), 32'hA5_3C_81_7E + 32'(w * 32'h0102_0304));
    wrReg(A_CLR, 32'hFFFF_FFFF);
    for (int w = 0; w < 8; w++) begin
      rdReg(A_SEL + 12'(4*w), v);
      chk("R2 select readback", v, 32'hA5_3C_81_7E + 32'(w * 32'h0102_0304));
    end
    for (int w = 0; w < 8; w++) wrReg(A_SEL + 12'(4*w), 32'h0);
    wrReg(A_CLR, 32'hFFFF_FFFF);
    rdReg(A_STAT, v); chk("R2 status clean", v, 32'h0);

    // R4/R5: sweep every channel through rising and falling modes
    for (int c = 0; c < CHS; c++) begin
      int p;
      p = (c * 7 + 3) % PINS;
      setSense(c, 2'd0);
      setChan(c, p, 1'b1);
      wrReg(A_CLR, 32'(1) << c);
      @(negedge clk); pins[p] = 1'b1;
      idle(2);
      expectChan("R4 rise latency", c, 1'b0, 1'b0);
      idle(1);
      expectChan("R4 rise sets", c, 1'b1, 1'b1);
      wrReg(A_CLR, ~(32'(1) << c));
      expectChan("R5 zero bits ignored", c, 1'b1, 1'b1);
      wrReg(A_CLR, 32'(1) << c);
      expectChan("R5 clear", c, 1'b0, 1'b0);
      @(negedge clk); pins[p] = 1'b0;
      idle(4);
      expectChan("R4 fall ignored in rise mode", c, 1'b0, 1'b0);
      setSense(c, 2'd1);
      @(negedge clk); pins[p] = 1'b1;
      idle(4);
      expectChan("R4 rise ignored in fall mode", c, 1'b0, 1'b0);
      @(negedge clk); pins[p] = 1'b0;
      idle(4);
      expectChan("R4 fall sets", c, 1'b1, 1'b1);
      wrReg(A_CLR, 32'(1) << c);
      expectChan("R5 clear fall", c, 1'b0, 1'b0);
      setChan(c, 0, 1'b0);
      setSense(c, 2'd0);
    end

    // R6: level modes on channel 5, pin 10
    setSense(5, 2'd2); setChan(5, 10, 1'b1);
    idle(3);
    expectChan("R6 high mode pin low", 5, 1'b0, 1'b0);
    @(negedge clk); pins[10] = 1'b1;
    idle(3);
    expectChan("R6 high mode pin high", 5, 1'b1, 1'b1);
    wrReg(A_CLR, 32'(1) << 5);
    expectChan("R6 clear ignored", 5, 1'b1, 1'b1);
    @(negedge clk); pins[10] = 1'b0;
    idle(3);
    expectChan("R6 high mode follows low", 5, 1'b0, 1'b0);
    setSense(5, 2'd3);
    idle(2);
    expectChan("R6 low mode pin low", 5, 1'b1, 1'b1);
    wrReg(A_CLR, 32'(1) << 5);
    expectChan("R6 low mode clear ignored", 5, 1'b1, 1'b1);
    @(negedge clk); pins[10] = 1'b1;
    idle(3);
    expectChan("R6 low mode pin high", 5, 1'b0, 1'b0);
    setChan(5, 0, 1'b0); setSense(5, 2'd0);
    @(negedge clk); pins[10] = 1'b0;
    idle(4);

    // R3: out-of-range selects route nothing
    setSense(6, 2'd0); setChan(6, 7'h56, 1'b1);
    @(negedge clk); pins = '1;
    idle(4);
    expectChan("R3 select 0x56 rise", 6, 1'b0, 1'b0);
    setChan(6, 7'h7F, 1'b1); setSense(6, 2'd2);
    idle(4);
    expectChan("R3 select 0x7F level", 6, 1'b0, 1'b0);
    setSense(6, 2'd3);
    @(negedge clk); pins = '0;
    idle(4);
    expectChan("R3 select 0x7F low level", 6, 1'b0, 1'b0);
    setSense(6, 2'd0); setChan(6, 0, 1'b0);
    wrReg(A_CLR, 32'hFFFF_FFFF);

    // R7: disabled channel
    setSense(7, 2'd0); setChan(7, 20, 1'b1);
    @(negedge clk); pins[20] = 1'b1;
    idle(3);
    expectChan("R7 set before disable", 7, 1'b1, 1'b1);
    setChan(7, 20, 1'b0);
    expectChan("R7 latched flag kept, irq off", 7, 1'b1, 1'b0);
    wrReg(A_CLR, 32'(1) << 7);
    expectChan("R7 clear while off", 7, 1'b0, 1'b0);
    @(negedge clk); pins[20] = 1'b0;
    idle(4);
    @(negedge clk); pins[20] = 1'b1;
    idle(4);
    expectChan("R7 no set while off", 7, 1'b0, 1'b0);
    setChan(7, 20, 1'b1);
    idle(4);
    expectChan("R7 enable gives no edge", 7, 1'b0, 1'b0);
    setChan(7, 0, 1'b0);
    @(negedge clk); pins[20] = 1'b0;
    idle(4);

    // R8: reselect between pins at opposite levels
    @(negedge clk); pins[30] = 1'b0; pins[31] = 1'b1;
    setSense(8, 2'd0); setChan(8, 30, 1'b1);
    idle(4);
    wrReg(A_CLR, 32'(1) << 8);
    setChan(8, 31, 1'b1);
    idle(4);
    expectChan("R8 reselect low->high no edge", 8, 1'b0, 1'b0);
    wrReg(A_CLR, 32'(1) << 8);
    expectChan("R8 clear after update", 8, 1'b0, 1'b0);
    setSense(8, 2'd1);
    setChan(8, 30, 1'b1);
    idle(4);
    expectChan("R8 reselect high->low no edge", 8, 1'b0, 1'b0);
    setChan(8, 0, 1'b0); setSense(8, 2'd0);
    @(negedge clk); pins[31] = 1'b0;
    idle(4);

    // R9: edge and clear in the same cycle
    setSense(9, 2'd0); setChan(9, 40, 1'b1);
    @(negedge clk); pins[40] = 1'b1;
    idle(3);
    expectChan("R9 precondition set", 9, 1'b1, 1'b1);
    @(negedge clk); pins[40] = 1'b0;
    idle(4);
    @(negedge clk); pins[40] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = A_CLR; busWrData = 32'(1) << 9;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = A_STAT; busWrData = '0;
    expectChan("R9 edge beats clear", 9, 1'b1, 1'b1);
    wrReg(A_CLR, 32'(1) << 9);
    expectChan("R9 later clear works", 9, 1'b0, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule